// File: doc/BRIEF.md
# Paged Address Translator with Debug Overlay

This block turns a 16-bit local CPU address into an 18-bit global address. The local map has three parts. The lower half passes through with two leading zero bits. A 16 KB window at 0x8000–0xBFFF is steered to one of sixteen program pages by a 4-bit page index register. The top 16 KB at 0xC000–0xFFFF always lands on the last page. The page index register is itself reachable at a fixed local register address, so software moves the window with an ordinary store.

A debug overlay sits on top of this translation. While the debug-active input is high, the top 256 bytes of the local map (0xFF00–0xFFFF) select debug resources instead of normal memory. When the page index also holds 0x0F, the top 256 bytes of the window (0xBF00–0xBFFF) select those resources too. The global address is still produced as usual, but the memory select is withheld so that the normal resource hidden under the overlay never responds. With debug inactive the overlay is never selected.

Translation and selection are combinational. Only the page index register is clocked.

Top module: `page_xlat`

## Requirements
- R1: After reset, the page index register holds 0x0F, and a read of it returns 0x0F.
- R2: For local addresses 0x8000–0xBFFF, globalAddr equals {page[3:0], cpuAddr[13:0]}.
- R3: For local addresses 0xC000–0xFFFF, globalAddr equals {4'hF, cpuAddr[13:0]} whatever the page value. For 0x0000–0x7FFF, globalAddr equals {2'b00, cpuAddr}.
- R4: While dbgActive is 1, every address in 0xFF00–0xFFFF drives dbgSel to 1, and 0xFEFF drives it to 0.
- R5: While dbgActive is 1 and the page equals 0x0F, every address in 0xBF00–0xBFFF drives dbgSel to 1. With any other page value, or at 0xBEFF, dbgSel is 0 in the window.
- R6: memSel is 1 exactly when rdEn or wrEn is 1, dbgSel is 0, and cpuAddr is not the page register address 0x0015. So dbgSel and memSel are never both 1.
- R7: While dbgActive is 0, dbgSel is 0 for every address and page value.
- R8: A cycle with wrEn=1 at cpuAddr 0x0015 loads wrData[3:0] into the page register at the next rising clock edge, and wrData[7:4] is ignored. A write to any other address leaves the page unchanged.
- R9: With rdEn=1 at 0x0015, pageRdData equals {4'b0000, page}. At any other time pageRdData is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuAddr | input | 16 | Local CPU address |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data (low four bits feed the page register) |
| dbgActive | input | 1 | Debug mode active flag |
| globalAddr | output | 18 | Translated global address |
| dbgSel | output | 1 | Debug overlay resource select |
| memSel | output | 1 | Normal memory select for a strobed access |
| pageRdData | output | 8 | Page register read value |

## Verification
The assertions assume that cpuAddr, the strobes and dbgActive are stable around the rising edge. The R8 property also assumes that the write strobe and address are sampled in the same cycle. The bench changes every input only just after the falling edge and samples 1 ns later, which keeps it within these assumptions. Random cycles allow rdEn and wrEn together. Writes land on the page register address often enough to move the window many times, so the overlay logic sees both page 0x0F and other pages while debug mode toggles.

// File: rtl/page_xlat_pkg.sv
package page_xlat_pkg;

  // Strobes handed from the decode control to the datapath
  typedef struct packed {
    logic pageWr;     // load page register at next edge
    logic pageRd;     // drive page value onto read bus
    logic inWindow;   // address falls in the paged window
    logic inUnpaged;  // address falls in the fixed top region
  } xlatStrobes_t;

endpackage

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import page_xlat_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int PAGE_W         = 4,
  parameter int DBG_SPAN_W     = 8,
  parameter logic [ADDR_W-1:0] PAGE_REG_ADDR = 16'h0015,
  parameter logic [PAGE_W-1:0] DBG_PAGE      = 4'hF,
  parameter bit  WIN_OVERLAY_EN = 1'b1
) (
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic              dbgActive,
  input  logic [PAGE_W-1:0] curPage,
  output xlatStrobes_t      strobes,
  output logic              dbgSel,
  output logic              memSel
);

  localparam logic [1:0] WIN_TAG = 2'b10;
  localparam logic [1:0] UNP_TAG = 2'b11;

  logic [1:0] regionTag;
  logic       pageHit;
  logic       topHit;
  logic       winTopHit;
  logic       winOverlay;

  assign regionTag = cpuAddr[ADDR_W-1 -: 2];
  assign pageHit   = (cpuAddr == PAGE_REG_ADDR);

  // Top span of the whole map: every bit above the span is one
  assign topHit    = &cpuAddr[ADDR_W-1:DBG_SPAN_W];
  // Top span of the window: window tag plus ones below the tag
  assign winTopHit = (regionTag == WIN_TAG) && (&cpuAddr[ADDR_W-3:DBG_SPAN_W]);

  generate
    if (WIN_OVERLAY_EN) begin : g_winOverlay
      assign winOverlay = winTopHit && (curPage == DBG_PAGE);
    end else begin : g_noWinOverlay
      assign winOverlay = 1'b0;
    end
  endgenerate

  always_comb begin
    dbgSel            = dbgActive && (topHit || winOverlay);
    memSel            = (rdEn || wrEn) && !dbgSel && !pageHit;
    strobes.pageWr    = wrEn && pageHit;
    strobes.pageRd    = rdEn && pageHit;
    strobes.inWindow  = (regionTag == WIN_TAG);
    strobes.inUnpaged = (regionTag == UNP_TAG);
  end

endmodule

// File: rtl/xlat_datapath.sv
module xlat_datapath
  import page_xlat_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int PAGE_W  = 4,
  parameter int DATA_W  = 8,
  parameter logic [PAGE_W-1:0] RESET_PAGE   = 4'hF,
  parameter logic [PAGE_W-1:0] UNPAGED_PAGE = 4'hF
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ADDR_W-1:0]         cpuAddr,
  input  logic [DATA_W-1:0]         wrData,
  input  xlatStrobes_t              strobes,
  output logic [PAGE_W-1:0]         curPage,
  output logic [PAGE_W+ADDR_W-3:0]  globalAddr,
  output logic [DATA_W-1:0]         pageRdData
);

  localparam int OFS_W   = ADDR_W - 2;
  localparam int GADDR_W = PAGE_W + OFS_W;
  localparam int PAD_W   = GADDR_W - ADDR_W;

  logic [PAGE_W-1:0] pageQ;
  logic [OFS_W-1:0]  offset;
  logic              unusedHiBits;

  assign unusedHiBits = ^wrData[DATA_W-1:PAGE_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               pageQ <= RESET_PAGE;
    else if (strobes.pageWr) pageQ <= wrData[PAGE_W-1:0];
  end

  assign curPage = pageQ;
  assign offset  = cpuAddr[OFS_W-1:0];

  always_comb begin
    if (strobes.inWindow)       globalAddr = {pageQ, offset};
    else if (strobes.inUnpaged) globalAddr = {UNPAGED_PAGE, offset};
    else                        globalAddr = {{PAD_W{1'b0}}, cpuAddr};
  end

  assign pageRdData = strobes.pageRd ? {{(DATA_W-PAGE_W){1'b0}}, pageQ} : '0;

endmodule

// File: rtl/page_xlat.sv
module page_xlat
  import page_xlat_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int PAGE_W     = 4,
  parameter int DATA_W     = 8,
  parameter int DBG_SPAN_W = 8,
  parameter logic [ADDR_W-1:0] PAGE_REG_ADDR = 16'h0015,
  parameter logic [PAGE_W-1:0] RESET_PAGE    = 4'hF,
  parameter logic [PAGE_W-1:0] DBG_PAGE      = 4'hF,
  parameter bit  WIN_OVERLAY_EN = 1'b1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ADDR_W-1:0]         cpuAddr,
  input  logic                      rdEn,
  input  logic                      wrEn,
  input  logic [DATA_W-1:0]         wrData,
  input  logic                      dbgActive,
  output logic [PAGE_W+ADDR_W-3:0]  globalAddr,
  output logic                      dbgSel,
  output logic                      memSel,
  output logic [DATA_W-1:0]         pageRdData
);

  xlatStrobes_t      strobes;
  logic [PAGE_W-1:0] curPage;

  xlat_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DBG_SPAN_W(DBG_SPAN_W),
    .PAGE_REG_ADDR(PAGE_REG_ADDR), .DBG_PAGE(DBG_PAGE),
    .WIN_OVERLAY_EN(WIN_OVERLAY_EN)
  ) u_ctrl (
    .cpuAddr(cpuAddr), .rdEn(rdEn), .wrEn(wrEn), .dbgActive(dbgActive),
    .curPage(curPage), .strobes(strobes), .dbgSel(dbgSel), .memSel(memSel)
  );

  xlat_datapath #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W),
    .RESET_PAGE(RESET_PAGE), .UNPAGED_PAGE({PAGE_W{1'b1}})
  ) u_dp (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .wrData(wrData),
    .strobes(strobes), .curPage(curPage), .globalAddr(globalAddr),
    .pageRdData(pageRdData)
  );

endmodule

// File: rtl/page_xlat_chk.sv
module page_xlat_chk #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] PAGE_REG_ADDR = 16'h0015
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [ADDR_W-1:0]         cpuAddr,
  input logic                      rdEn,
  input logic                      wrEn,
  input logic [DATA_W-1:0]         wrData,
  input logic                      dbgActive,
  input logic [PAGE_W+ADDR_W-3:0]  globalAddr,
  input logic                      dbgSel,
  input logic                      memSel,
  input logic [DATA_W-1:0]         pageRdData
);

  a_r3_unpaged_fixed: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr[ADDR_W-1 -: 2] == 2'b11) |->
      (globalAddr == {{PAGE_W{1'b1}}, cpuAddr[ADDR_W-3:0]}));

  a_r4_top_overlay: assert property (@(posedge clk) disable iff (!rstN)
    (dbgActive && (&cpuAddr[ADDR_W-1:8])) |-> dbgSel);

  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(dbgSel && memSel));

  a_r7_quiet_inactive: assert property (@(posedge clk) disable iff (!rstN)
    !dbgActive |-> !dbgSel);

  a_r8_write_next: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && cpuAddr == PAGE_REG_ADDR) |=>
      ((cpuAddr[ADDR_W-1 -: 2] != 2'b10) ||
       (globalAddr[PAGE_W+ADDR_W-3 -: PAGE_W] == $past(wrData[PAGE_W-1:0]))));

  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (pageRdData[DATA_W-1:PAGE_W] == '0) && (!rdEn -> pageRdData == '0));

endmodule

bind page_xlat page_xlat_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W),
  .PAGE_REG_ADDR(PAGE_REG_ADDR)
) u_chk (.*);

// File: tb/page_xlat_bench.sv
`timescale 1ns/1ps
module page_xlat_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic        rdEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic        dbgActive = 1'b0;
  logic [17:0] globalAddr;
  logic        dbgSel;
  logic        memSel;
  logic [7:0]  pageRdData;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [3:0] shadowPage;

  always #2.5 clk = ~clk;

  page_xlat u_page_xlat (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .dbgActive(dbgActive), .globalAddr(globalAddr),
    .dbgSel(dbgSel), .memSel(memSel), .pageRdData(pageRdData)
  );

  function automatic logic [17:0] expGlobal(logic [15:0] a, logic [3:0] p);
    if (a[15:14] == 2'b10)      return {p, a[13:0]};
    else if (a[15:14] == 2'b11) return {4'hF, a[13:0]};
    else                        return {2'b00, a};
  endfunction

  function automatic logic expDbg(logic [15:0] a, logic [3:0] p, logic act);
    return act && ((a[15:8] == 8'hFF) || (a[15:8] == 8'hBF && p == 4'hF));
  endfunction

  function automatic logic expMem(logic [15:0] a, logic [3:0] p, logic act,
                                  logic rd, logic wr);
    return (rd || wr) && !expDbg(a, p, act) && (a != 16'h0015);
  endfunction

  function automatic logic [7:0] expRd(logic [15:0] a, logic [3:0] p, logic rd);
    return (rd && a == 16'h0015) ? {4'h0, p} : 8'h00;
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s addr=%h page=%h dbg=%b: got %h expected %h",
               req, cpuAddr, shadowPage, dbgActive, got, exp);
    end
  endtask

  // Drive one access just after the falling edge, check 1 ns later
  task automatic access(logic [15:0] a, logic rd, logic wr, logic [7:0] d, logic act);
    @(negedge clk);
    cpuAddr = a; rdEn = rd; wrEn = wr; wrData = d; dbgActive = act;
    #1;
    chk("R2/R3 globalAddr", 32'(globalAddr), 32'(expGlobal(a, shadowPage)));
    chk("R4/R5/R7 dbgSel", 32'(dbgSel), 32'(expDbg(a, shadowPage, act)));
    chk("R6 memSel", 32'(memSel), 32'(expMem(a, shadowPage, act, rd, wr)));
    chk("R9 pageRdData", 32'(pageRdData), 32'(expRd(a, shadowPage, rd)));
    if (wr && a == 16'h0015) shadowPage = d[3:0];   // R8: lands at next edge
  endtask

  task automatic idle();
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b0;
  endtask

  initial begin
    #500000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    shadowPage = 4'hF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset value read back
    access(16'h0015, 1'b1, 1'b0, 8'h00, 1'b0);
    chk("R1 reset page", 32'(pageRdData), 32'h0F);

    // R2, R5, R7, R8, R9: sweep every page across the window
    for (int p = 0; p < 16; p++) begin
      access(16'h0015, 1'b0, 1'b1, {4'hA, 4'(p)}, 1'b0);   // R8 upper bits ignored
      access(16'h0015, 1'b1, 1'b0, 8'h00, 1'b0);
      chk("R8 page readback", 32'(pageRdData), 32'(p));
      access(16'h8000, 1'b1, 1'b0, 8'h00, 1'b0);
      access(16'hBFFF, 1'b1, 1'b0, 8'h00, 1'b0);
      access(16'hA5A5, 1'b0, 1'b1, 8'h33, 1'b1);
      for (int act = 0; act < 2; act++) begin
        access(16'hBEFF, 1'b1, 1'b0, 8'h00, 1'(act));
        access(16'hBF00, 1'b1, 1'b0, 8'h00, 1'(act));
        chk("R5 window overlay", 32'(dbgSel), 32'(act == 1 && p == 15));
      end
      access(16'hC123, 1'b1, 1'b0, 8'h00, 1'b0);           // R3 page independent
    end

    // R4, R7: top overlay boundary in both modes
    for (int act = 0; act < 2; act++) begin
      access(16'hFEFF, 1'b1, 1'b0, 8'h00, 1'(act));
      chk("R4 below overlay", 32'(dbgSel), 32'h0);
      access(16'hFF00, 1'b1, 1'b0, 8'h00, 1'(act));
      chk("R4 overlay start", 32'(dbgSel), 32'(act));
      access(16'hFFFF, 1'b0, 1'b1, 8'h00, 1'(act));
      chk("R6 hidden memory", 32'(memSel), 32'(act == 0));
    end

    // R8: write elsewhere leaves the page unchanged; R3 low half
    access(16'h0016, 1'b0, 1'b1, 8'h03, 1'b0);
    access(16'h0015, 1'b1, 1'b0, 8'h00, 1'b0);
    chk("R8 other write ignored", 32'(pageRdData), 32'(shadowPage));
    access(16'h7FFF, 1'b0, 1'b0, 8'h00, 1'b1);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      a = 16'($urandom);
      case ($urandom_range(0, 5))
        0: a = 16'h0015;
        1: a = {8'hBF, a[7:0]};
        2: a = {8'hFF, a[7:0]};
        default: ;
      endcase
      access(a, 1'($urandom), 1'($urandom), 8'($urandom), 1'($urandom));
    end

    idle();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule